// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block sits next to the instruction decoder of a core with a hypervisor extension. It holds a copy of the privilege and status state that affects legality. That state is the privilege level, the virtualization bit, the virtual-memory trap bits, the wait-timeout trap bits, the hypervisor user-access bit, the floating-point and vector unit state fields, and the dynamic rounding mode. A write-enable port loads this state into registers.

Each cycle the decoder presents a class code for the instruction it is handling. One cycle later the block returns two verdicts: whether decode must raise an illegal-instruction exception, and whether it must raise a virtual-instruction exception. The privilege level and the virtualization bit are first turned into one of five named modes: MODE_M, MODE_HS, MODE_HU, MODE_VS and MODE_VU. A mode is not a state of a sequence. It changes only when the status register is written, and any mode can follow any other.

A separate registered flag reports when the stored rounding mode holds a reserved value.

Top module: `priv_legality_checker`

## Requirements
- R1: While reset is asserted, all three outputs are 0. The status register resets to level 3 (machine), virtualization 0, every trap bit 0, both unit state fields 0 (Off) and rounding mode 0.
- R2: A write with `cfg_we`=1 loads every status field at the clock edge. Level encoding is 0=user, 1=supervisor, 3=machine. With level 1 or 0, `cfg_virt` selects the virtual mode (VS, VU) instead of HS or HU. Level 3 is machine mode whatever `cfg_virt` is, and raises no privilege verdict.
- R3: A write whose level is 2 (reserved) is ignored as a whole: no status field changes.
- R4: Classes 0 (supervisor translation fence) and 2 (guest-physical fence) are illegal in HU mode, and in HS mode when the trap-virtual-memory bit is 1.
- R5: Classes 1 (partial fences) and 3 (virtual-machine fence) are illegal only in HU mode.
- R6: Class 4 (hypervisor load/store) is illegal in HU mode when the hypervisor user-access bit is 0.
- R7: Class 5 (wait-for-interrupt) is illegal in HU mode, and in any mode other than machine when the timeout-wait bit is 1.
- R8: Class 6 (scalar FP) is illegal when the FP state field is 0 (Off). Class 7 (vector) is illegal when the vector state field is 0. Class 8 (vector FP) is illegal when either field is 0.
- R9: `frm_reserved` is 1 exactly when the stored rounding mode is greater than 4.
- R10: Class 0 raises a virtual-instruction verdict in VU mode, and in VS mode when the virtual trap-virtual-memory bit is 1. Class 1 raises it only in VU mode.
- R11: Classes 2, 3 and 4 raise a virtual-instruction verdict in VS and VU modes.
- R12: Class 5 raises a virtual-instruction verdict when the timeout-wait bit is 0 and the mode is VU, or the mode is VS with the virtual timeout-wait bit 1.
- R13: The verdicts registered at an edge use the class code presented at that edge and the status held before it. A status write at the same edge only affects the following cycle. Class codes 9 to 15 raise nothing.
- R14: The two verdicts are never both 1, and classes 6 to 15 never raise a virtual-instruction verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Status write enable |
| cfg_level | input | 2 | Privilege level to store |
| cfg_virt | input | 1 | Virtualization bit to store |
| cfg_tvm | input | 1 | Trap virtual-memory fences (HS) |
| cfg_tw | input | 1 | Timeout-wait trap bit |
| cfg_hu | input | 1 | Hypervisor user-access bit |
| cfg_vtvm | input | 1 | Virtual trap virtual-memory bit (VS) |
| cfg_vtw | input | 1 | Virtual timeout-wait bit (VS) |
| cfg_fs | input | 2 | FP unit state, 0 = Off |
| cfg_vs | input | 2 | Vector unit state, 0 = Off |
| cfg_frm | input | 3 | Dynamic rounding mode |
| cls_i | input | 4 | Instruction class code |
| raise_ill | output | 1 | Illegal-instruction verdict |
| raise_virt | output | 1 | Virtual-instruction verdict |
| frm_reserved | output | 1 | Stored rounding mode is reserved |

## Verification
The bench loads every combination of level, virtualization bit, the five trap bits and the two unit state fields. It then presents all sixteen class codes against each loaded state, so that each mode meets each class under every bit that could qualify it. Sweeping the trap bits separates the HS and VS qualifiers from the HU and VU ones. The reserved level 2 appears in the sweep, and there the expected state simply stays at the previous write, which shows that the write was dropped. Directed cases cover the reset values and machine mode with the virtualization bit set. A further case writes the status in the same cycle as a class code, which shows that the verdict still uses the old status.

// File: rtl/plc_pkg.sv
package plc_pkg;

    localparam int XS_W  = 2;   // unit state field width
    localparam int RM_W  = 3;   // rounding mode width
    localparam int LVL_W = 2;

    localparam int CLS_FENCE_VMA  = 0;
    localparam int CLS_FENCE_PART = 1;
    localparam int CLS_HFENCE_G   = 2;
    localparam int CLS_HFENCE_V   = 3;
    localparam int CLS_HLDST      = 4;
    localparam int CLS_WFI        = 5;
    localparam int CLS_FP         = 6;
    localparam int CLS_VEC        = 7;
    localparam int CLS_VECFP      = 8;

    typedef enum logic [2:0] {
        MODE_M  = 3'd0,
        MODE_HS = 3'd1,
        MODE_HU = 3'd2,
        MODE_VS = 3'd3,
        MODE_VU = 3'd4
    } mode_t;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             virt;
        logic             tvm;
        logic             tw;
        logic             hu;
        logic             vtvm;
        logic             vtw;
        logic [XS_W-1:0]  fs;
        logic [XS_W-1:0]  vs;
        logic [RM_W-1:0]  frm;
    } status_t;

    function automatic logic ill_rule(int k, mode_t m, logic tvm, logic tw,
                                      logic hu, logic fs_off, logic vs_off);
        logic hu_m;
        hu_m = (m == MODE_HU);
        case (k)
            CLS_FENCE_VMA,
            CLS_HFENCE_G:   return hu_m || (m == MODE_HS && tvm);
            CLS_FENCE_PART,
            CLS_HFENCE_V:   return hu_m;
            CLS_HLDST:      return hu_m && !hu;
            CLS_WFI:        return hu_m || (m != MODE_M && tw);
            CLS_FP:         return fs_off;
            CLS_VEC:        return vs_off;
            CLS_VECFP:      return fs_off || vs_off;
            default:        return 1'b0;
        endcase
    endfunction

    function automatic logic virt_rule(int k, mode_t m, logic tw,
                                       logic vtvm, logic vtw);
        logic guest;
        guest = (m == MODE_VS) || (m == MODE_VU);
        case (k)
            CLS_FENCE_VMA:  return (m == MODE_VU) || (m == MODE_VS && vtvm);
            CLS_FENCE_PART: return (m == MODE_VU);
            CLS_HFENCE_G,
            CLS_HFENCE_V,
            CLS_HLDST:      return guest;
            CLS_WFI:        return !tw && ((m == MODE_VU) || (m == MODE_VS && vtw));
            default:        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/plc_status_regs.sv
module plc_status_regs
    import plc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    we,
    input  status_t wr,
    output status_t st_q
);
    localparam logic [LVL_W-1:0] LVL_RSVD = 2'd2;
    localparam logic [LVL_W-1:0] LVL_MACH = 2'd3;

    logic accept;
    assign accept = we && (wr.level != LVL_RSVD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.level <= LVL_MACH;
        end else if (accept) begin
            st_q <= wr;
        end
    end
endmodule

// File: rtl/plc_mode_decode.sv
module plc_mode_decode
    import plc_pkg::*;
(
    input  logic [LVL_W-1:0] level,
    input  logic             virt,
    output mode_t            mode
);
    always_comb begin
        unique case (level)
            2'd1:    mode = virt ? MODE_VS : MODE_HS;
            2'd0:    mode = virt ? MODE_VU : MODE_HU;
            default: mode = MODE_M;   // level 2 never stored
        endcase
    end
endmodule

// File: rtl/plc_class_rules.sv
module plc_class_rules
    import plc_pkg::*;
#(
    parameter int NUM_CLS = 16
) (
    input  mode_t             mode,
    input  logic              tvm,
    input  logic              tw,
    input  logic              hu,
    input  logic              vtvm,
    input  logic              vtw,
    input  logic [XS_W-1:0]   fs,
    input  logic [XS_W-1:0]   vs,
    output logic [NUM_CLS-1:0] ill_vec,
    output logic [NUM_CLS-1:0] virt_vec
);
    logic fs_off, vs_off;
    assign fs_off = (fs == '0);
    assign vs_off = (vs == '0);

    for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
        assign ill_vec[k]  = ill_rule(k, mode, tvm, tw, hu, fs_off, vs_off);
        assign virt_vec[k] = virt_rule(k, mode, tw, vtvm, vtw);
    end
endmodule

// File: rtl/priv_legality_checker.sv
module priv_legality_checker
    import plc_pkg::*;
#(
    parameter int CLS_W   = 4,
    parameter int FRM_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_level,
    input  logic             cfg_virt,
    input  logic             cfg_tvm,
    input  logic             cfg_tw,
    input  logic             cfg_hu,
    input  logic             cfg_vtvm,
    input  logic             cfg_vtw,
    input  logic [1:0]       cfg_fs,
    input  logic [1:0]       cfg_vs,
    input  logic [2:0]       cfg_frm,
    input  logic [CLS_W-1:0] cls_i,
    output logic             raise_ill,
    output logic             raise_virt,
    output logic             frm_reserved
);
    localparam int NUM_CLS = 2 ** CLS_W;

    status_t              st_wr, st_q;
    mode_t                mode;
    logic [NUM_CLS-1:0]   ill_vec, virt_vec;

    always_comb begin
        st_wr.level = cfg_level;
        st_wr.virt  = cfg_virt;
        st_wr.tvm   = cfg_tvm;
        st_wr.tw    = cfg_tw;
        st_wr.hu    = cfg_hu;
        st_wr.vtvm  = cfg_vtvm;
        st_wr.vtw   = cfg_vtw;
        st_wr.fs    = cfg_fs;
        st_wr.vs    = cfg_vs;
        st_wr.frm   = cfg_frm;
    end

    plc_status_regs u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .wr   (st_wr),
        .st_q (st_q)
    );

    plc_mode_decode u_mode (
        .level(st_q.level),
        .virt (st_q.virt),
        .mode (mode)
    );

    plc_class_rules #(.NUM_CLS(NUM_CLS)) u_rules (
        .mode    (mode),
        .tvm     (st_q.tvm),
        .tw      (st_q.tw),
        .hu      (st_q.hu),
        .vtvm    (st_q.vtvm),
        .vtw     (st_q.vtw),
        .fs      (st_q.fs),
        .vs      (st_q.vs),
        .ill_vec (ill_vec),
        .virt_vec(virt_vec)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raise_ill    <= 1'b0;
            raise_virt   <= 1'b0;
            frm_reserved <= 1'b0;
        end else begin
            raise_ill    <= ill_vec[cls_i];
            raise_virt   <= virt_vec[cls_i];
            frm_reserved <= (32'(st_q.frm) > FRM_MAX);
        end
    end
endmodule

// File: rtl/plc_checker.sv
module plc_checker
    import plc_pkg::*;
#(
    parameter int CLS_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_level,
    input logic [CLS_W-1:0] cls_i,
    input logic             raise_ill,
    input logic             raise_virt,
    input logic             frm_reserved,
    input status_t          st_q,
    input mode_t            mode
);
    a_r14_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(raise_ill && raise_virt));

    a_r14_no_virt_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cls_i) >= CLS_FP) |=> !raise_virt);

    a_r2_mach_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_M && 32'(cls_i) < CLS_FP) |=> (!raise_ill && !raise_virt));

    a_r2_level_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_level != 2'd2) |=> (st_q.level == $past(cfg_level)));

    a_r3_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_level == 2'd2) |=> $stable(st_q));

    a_r9_frm_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.frm > 3'd4) |=> frm_reserved);

    a_r9_frm_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.frm <= 3'd4) |=> !frm_reserved);
endmodule

bind priv_legality_checker plc_checker #(.CLS_W(CLS_W)) u_plc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_level   (cfg_level),
    .cls_i       (cls_i),
    .raise_ill   (raise_ill),
    .raise_virt  (raise_virt),
    .frm_reserved(frm_reserved),
    .st_q        (st_q),
    .mode        (mode)
);

// File: tb/test_priv_legality_checker.sv
module test_priv_legality_checker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_level = 2'd0;
    logic cfg_virt = 1'b0, cfg_tvm = 1'b0, cfg_tw = 1'b0, cfg_hu = 1'b0;
    logic cfg_vtvm = 1'b0, cfg_vtw = 1'b0;
    logic [1:0] cfg_fs = 2'd0, cfg_vs = 2'd0;
    logic [2:0] cfg_frm = 3'd0;
    logic [3:0] cls_i = 4'd0;
    logic raise_ill, raise_virt, frm_reserved;

    int errors = 0;
    int checks = 0;

    // model of stored status
    int m_lvl = 3, m_v = 0, m_tvm = 0, m_tw = 0, m_hu = 0, m_vtvm = 0, m_vtw = 0;
    int m_fs = 0, m_vs = 0, m_frm = 0;

    always #10 clk = ~clk;

    priv_legality_checker i_priv_legality_checker (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_level(cfg_level),
        .cfg_virt(cfg_virt), .cfg_tvm(cfg_tvm), .cfg_tw(cfg_tw), .cfg_hu(cfg_hu),
        .cfg_vtvm(cfg_vtvm), .cfg_vtw(cfg_vtw), .cfg_fs(cfg_fs), .cfg_vs(cfg_vs),
        .cfg_frm(cfg_frm), .cls_i(cls_i), .raise_ill(raise_ill),
        .raise_virt(raise_virt), .frm_reserved(frm_reserved)
    );

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b (cls=%0d lvl=%0d v=%0d)",
                     req, act, exp, cls_i, m_lvl, m_v);
        end
    endtask

    function automatic logic exp_ill(int c);
        logic hu_m, hs_m, mm, fo, vo;
        mm   = (m_lvl == 3);
        hs_m = (m_lvl == 1) && (m_v == 0);
        hu_m = (m_lvl == 0) && (m_v == 0);
        fo   = (m_fs == 0);
        vo   = (m_vs == 0);
        case (c)
            0, 2: return hu_m || (hs_m && m_tvm != 0);
            1, 3: return hu_m;
            4:    return hu_m && m_hu == 0;
            5:    return hu_m || (!mm && m_tw != 0);
            6:    return fo;
            7:    return vo;
            8:    return fo || vo;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_virt(int c);
        logic vs_m, vu_m;
        vs_m = (m_lvl == 1) && (m_v != 0);
        vu_m = (m_lvl == 0) && (m_v != 0);
        case (c)
            0:       return vu_m || (vs_m && m_vtvm != 0);
            1:       return vu_m;
            2, 3, 4: return vs_m || vu_m;
            5:       return (m_tw == 0) && (vu_m || (vs_m && m_vtw != 0));
            default: return 1'b0;
        endcase
    endfunction

    function automatic string ill_tag(int c);
        case (c)
            0, 2:    return "R4";
            1, 3:    return "R5";
            4:       return "R6";
            5:       return "R7";
            6, 7, 8: return "R8";
            default: return "R13";
        endcase
    endfunction

    function automatic string virt_tag(int c);
        case (c)
            0, 1:    return "R10";
            2, 3, 4: return "R11";
            5:       return "R12";
            default: return "R14";
        endcase
    endfunction

    // drive a write at a negedge; it takes effect at the next posedge
    task automatic write_status(int lvl, int v, int bits, int fs, int vs, int frm);
        cfg_we    = 1'b1;
        cfg_level = 2'(lvl);
        cfg_virt  = 1'(v);
        cfg_tvm   = bits[0];
        cfg_tw    = bits[1];
        cfg_hu    = bits[2];
        cfg_vtvm  = bits[3];
        cfg_vtw   = bits[4];
        cfg_fs    = 2'(fs);
        cfg_vs    = 2'(vs);
        cfg_frm   = 3'(frm);
        @(posedge clk);
        if (lvl != 2) begin   // R3: reserved level write is dropped
            m_lvl = lvl; m_v = v; m_tvm = bits[0]; m_tw = bits[1]; m_hu = bits[2];
            m_vtvm = bits[3]; m_vtw = bits[4]; m_fs = fs; m_vs = vs; m_frm = frm;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic try_class(int c, string ill_req, string virt_req);
        cls_i = 4'(c);
        @(posedge clk);
        @(negedge clk);
        check(ill_req, raise_ill, exp_ill(c));
        check(virt_req, raise_virt, exp_virt(c));
        check("R9", frm_reserved, m_frm > 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int idx = 0;
        repeat (3) @(negedge clk);
        // R1: outputs held at 0 in reset
        check("R1", raise_ill, 1'b0);
        check("R1", raise_virt, 1'b0);
        check("R1", frm_reserved, 1'b0);
        rst_n = 1'b1;
        // R1: reset status is machine with FP Off -> class 6 illegal
        try_class(6, "R1", "R1");
        try_class(0, "R1", "R1");

        // R2: machine mode with virt=1 raises nothing
        write_status(3, 1, 31, 1, 1, 0);
        for (int c = 0; c < 6; c++) try_class(c, "R2", "R2");

        // R3: reserved level write leaves FP On state untouched
        write_status(2, 0, 0, 0, 0, 7);
        try_class(6, "R3", "R3");
        try_class(8, "R3", "R3");

        // R13: write in the same cycle as class, old status used
        write_status(3, 0, 0, 0, 0, 0);
        cls_i     = 4'd6;
        cfg_we    = 1'b1;
        cfg_level = 2'd3;
        cfg_fs    = 2'd3;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        check("R13", raise_ill, 1'b1);
        m_fs = 3;
        try_class(6, "R13", "R13");

        // exhaustive sweep
        for (int lvl = 0; lvl < 4; lvl++)
            for (int v = 0; v < 2; v++)
                for (int bits = 0; bits < 32; bits++)
                    for (int fs = 0; fs < 4; fs++)
                        for (int vs = 0; vs < 4; vs++) begin
                            write_status(lvl, v, bits, fs, vs, idx % 8);
                            idx++;
                            for (int c = 0; c < 16; c++)
                                try_class(c, ill_tag(c), virt_tag(c));
                        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule